// File: doc/BRIEF.md
# Dual-Source Selecting Latch Bank

This block is a bank of identical one-bit lanes (four by default). Every lane has two data sources and one storage element. A two-bit select code is shared by all lanes. It decides what each lane stores:
- the first source,
- the second source,
- the OR of both sources, or
- a forced zero.

Storage only follows its input while both active-low enables are low. If either enable goes high, the stored value is frozen. A high clear input overrides everything else and empties every lane. Each lane drives its stored bit and the inverse of that bit.

The default build is a clocked-sample variant for synchronous flows. On each rising clock edge where both enables are low, a lane loads its decoded value. A parameter selects a level-sensitive latch instead. A second parameter makes the clear take effect asynchronously rather than at the clock edge. Driving the two select bits from one wire gives a plain two-way selector.

Top module: `dual_src_latch_bank`

## Requirements
- R1: With select code 2'b00 (sel[1]=0, sel[0]=0) and both enables low, each lane loads its `src0` bit. In the clocked variant the new value is visible after the rising edge.
- R2: With select code 2'b10 (sel[1]=1, sel[0]=0) and both enables low, each lane loads the OR of its `src0` and `src1` bits.
- R3: With select code 2'b01 (sel[1]=0, sel[0]=1) and both enables low, each lane loads 0, whatever its data bits are.
- R4: With select code 2'b11 and both enables low, each lane loads its `src1` bit.
- R5: While `en_a_n` or `en_b_n` is high and clear is low, `q` keeps the value it held before. Changes on `sel`, `src0` or `src1` have no effect.
- R6: A high `clear` forces every `q` bit to 0, whatever the enables, select and data are. In the default synchronous form this happens at the next rising edge.
- R7: `q_n` is always the bitwise inverse of `q`.
- R8: Lanes are independent. Lane i's result depends only on `src0[i]`, `src1[i]` and the shared controls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock (unused in latch variant) |
| clear | input | 1 | Active-high clear, overrides all other inputs |
| en_a_n | input | 1 | First active-low enable |
| en_b_n | input | 1 | Second active-low enable |
| sel | input | 2 | Shared select code |
| src0 | input | LANES | First data source, one bit per lane |
| src1 | input | LANES | Second data source, one bit per lane |
| q | output | LANES | Stored value per lane |
| q_n | output | LANES | Inverse of stored value per lane |

## Verification
The assertions assume the clocked variant. They also assume that the controls and data are settled at each rising edge, so `$past` of an input is the value the lane actually sampled. The stimulus changes every input only on the falling clock edge, half a period away from the sampling edge. The random phase mixes every select code, enable combination and occasional clear assertions. Clear pulses always last at least one full clock.

// File: rtl/dsl_pkg.sv
// Package: shared select encoding and the per-lane decode function.
// Assumes the select code is a two-bit value shared by every lane.
package dsl_pkg;

    typedef enum logic [1:0] {
        SEL_SRC0 = 2'b00,
        SEL_ZERO = 2'b01,
        SEL_OR   = 2'b10,
        SEL_SRC1 = 2'b11
    } sel_code_e;

    // Returns the bit a lane should store for a given code and data pair.
    function automatic logic pick_bit(input sel_code_e code, input logic a, input logic b);
        logic r;
        case (code)
            SEL_SRC0: r = a;
            SEL_ZERO: r = 1'b0;
            SEL_OR:   r = a | b;
            default:  r = b;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dsl_decode.sv
// Module: dsl_decode
// Combines the two sources of each lane under the shared select code.
// Assumes sel is stable whenever the storage stage samples it.
module dsl_decode #(
    parameter int LANES = 4
) (
    input  logic [1:0]       sel,
    input  logic [LANES-1:0] src0,
    input  logic [LANES-1:0] src1,
    output logic [LANES-1:0] value
);
    import dsl_pkg::*;

    sel_code_e code;

    // Cast the raw select bits to the named encoding.
    always_comb code = sel_code_e'(sel);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Decode one lane from its own pair of source bits.
        always_comb value[i] = pick_bit(code, src0[i], src1[i]);
    end
endmodule

// File: rtl/dsl_store.sv
// Module: dsl_store
// Holds one bit per lane. TRANSPARENT=0 gives clocked sampling and
// TRANSPARENT=1 gives a level-sensitive latch. ASYNC_CLEAR chooses an
// immediate or clock-edge clear in the clocked variant.
// Assumes pass is high only when both enables are low.
module dsl_store #(
    parameter int LANES       = 4,
    parameter bit TRANSPARENT = 1'b0,
    parameter bit ASYNC_CLEAR = 1'b0
) (
    input  logic             clk,
    input  logic             clear,
    input  logic             pass,
    input  logic [LANES-1:0] d,
    output logic [LANES-1:0] q
);
    if (TRANSPARENT) begin : g_latch
        // Follow d while passing, hold otherwise, clear wins.
        always_latch begin
            if (clear)     q = '0;
            else if (pass) q = d;
        end
    end else if (ASYNC_CLEAR) begin : g_async
        // Clocked sample with immediate clear.
        always_ff @(posedge clk or posedge clear) begin
            if (clear)     q <= '0;
            else if (pass) q <= d;
        end
    end else begin : g_sync
        // Clocked sample with clear applied at the edge.
        always_ff @(posedge clk) begin
            if (clear)     q <= '0;
            else if (pass) q <= d;
        end
    end
endmodule

// File: rtl/dual_src_latch_bank.sv
// Module: dual_src_latch_bank (top)
// A bank of selecting storage lanes with true and inverted outputs.
// Assumes both enables and the select code are shared by all lanes.
module dual_src_latch_bank #(
    parameter int LANES       = 4,
    parameter bit TRANSPARENT = 1'b0,
    parameter bit ASYNC_CLEAR = 1'b0
) (
    input  logic             clk,
    input  logic             clear,
    input  logic             en_a_n,
    input  logic             en_b_n,
    input  logic [1:0]       sel,
    input  logic [LANES-1:0] src0,
    input  logic [LANES-1:0] src1,
    output logic [LANES-1:0] q,
    output logic [LANES-1:0] q_n
);
    logic             pass;
    logic [LANES-1:0] decoded;
    logic [LANES-1:0] stored;

    // Storage passes data only when both active-low enables are low.
    always_comb pass = ~en_a_n & ~en_b_n;

    dsl_decode #(.LANES(LANES)) u_decode (
        .sel   (sel),
        .src0  (src0),
        .src1  (src1),
        .value (decoded)
    );

    dsl_store #(
        .LANES       (LANES),
        .TRANSPARENT (TRANSPARENT),
        .ASYNC_CLEAR (ASYNC_CLEAR)
    ) u_store (
        .clk   (clk),
        .clear (clear),
        .pass  (pass),
        .d     (decoded),
        .q     (stored)
    );

    // Drive the true and inverted outputs from the stored bits.
    always_comb begin
        q   = stored;
        q_n = ~stored;
    end
endmodule

// File: rtl/dsl_checker.sv
// Module: dsl_checker
// Property checks for the clocked variant, bound to the top module.
// Assumes inputs settle away from the rising clock edge.
module dsl_checker #(
    parameter int LANES       = 4,
    parameter bit TRANSPARENT = 1'b0
) (
    input logic             clk,
    input logic             clear,
    input logic             en_a_n,
    input logic             en_b_n,
    input logic [1:0]       sel,
    input logic [LANES-1:0] src0,
    input logic [LANES-1:0] src1,
    input logic [LANES-1:0] q
);
    if (!TRANSPARENT) begin : g_props
        assert_src0_R1: assert property (@(posedge clk) disable iff (clear)
            (!en_a_n && !en_b_n && sel == 2'b00) |=> (q == $past(src0)));

        assert_or_R2: assert property (@(posedge clk) disable iff (clear)
            (!en_a_n && !en_b_n && sel == 2'b10) |=> (q == ($past(src0) | $past(src1))));

        assert_zero_R3: assert property (@(posedge clk) disable iff (clear)
            (!en_a_n && !en_b_n && sel == 2'b01) |=> (q == '0));

        assert_src1_R4: assert property (@(posedge clk) disable iff (clear)
            (!en_a_n && !en_b_n && sel == 2'b11) |=> (q == $past(src1)));

        assert_hold_R5: assert property (@(posedge clk) disable iff (clear)
            (en_a_n || en_b_n) |=> $stable(q));

        assert_clear_R6: assert property (@(posedge clk)
            clear |=> (q == '0));
    end
endmodule

bind dual_src_latch_bank dsl_checker #(
    .LANES       (LANES),
    .TRANSPARENT (TRANSPARENT)
) u_checker (
    .clk    (clk),
    .clear  (clear),
    .en_a_n (en_a_n),
    .en_b_n (en_b_n),
    .sel    (sel),
    .src0   (src0),
    .src1   (src1),
    .q      (q)
);

// File: tb/dual_src_latch_bank_test.sv
// Bench: behavioural per-lane model compared with the outputs after every rising edge.
module dual_src_latch_bank_test;
    localparam int LANES = 4;

    logic             clk = 1'b0;
    logic             clear = 1'b1;
    logic             en_a_n = 1'b1;
    logic             en_b_n = 1'b1;
    logic [1:0]       sel = 2'b00;
    logic [LANES-1:0] src0 = '0;
    logic [LANES-1:0] src1 = '0;
    logic [LANES-1:0] q;
    logic [LANES-1:0] q_n;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    bit model [LANES];

    dual_src_latch_bank #(.LANES(LANES)) uut (
        .clk(clk), .clear(clear), .en_a_n(en_a_n), .en_b_n(en_b_n),
        .sel(sel), .src0(src0), .src1(src1), .q(q), .q_n(q_n)
    );

    always #2 clk = ~clk;  // 250 MHz

    // Update the model from the stated rules, then compare both outputs.
    task automatic step(input string tag);
        logic [LANES-1:0] exp;
        @(posedge clk);
        for (int i = 0; i < LANES; i++) begin
            if (clear) model[i] = 1'b0;
            else if (!en_a_n && !en_b_n) begin
                case (sel)
                    2'b00: model[i] = src0[i];
                    2'b01: model[i] = 1'b0;
                    2'b10: model[i] = src0[i] || src1[i];
                    default: model[i] = src1[i];
                endcase
            end
        end
        #1;
        for (int i = 0; i < LANES; i++) exp[i] = model[i];
        checks++;
        if (q !== exp) begin
            errors++;
            $display("FAIL %s: q=%b expected %b", tag, q, exp);
        end
        checks++;
        if (q_n !== ~exp) begin
            errors++;
            $display("FAIL R7 (%s): q_n=%b expected %b", tag, q_n, ~exp);
        end
        @(negedge clk);
    endtask

    task automatic drive(input logic c, input logic a, input logic b, input logic [1:0] s,
                         input logic [LANES-1:0] d0, input logic [LANES-1:0] d1);
        clear = c; en_a_n = a; en_b_n = b; sel = s; src0 = d0; src1 = d1;
    endtask

    initial begin
        @(negedge clk);
        drive(1, 0, 0, 2'b11, 4'hF, 4'hF); step("R6 reset state");
        drive(0, 0, 0, 2'b00, 4'b1010, 4'b0110); step("R1 src0 pattern A");
        drive(0, 0, 0, 2'b00, 4'b0101, 4'b1111); step("R1 src0 pattern B");
        drive(0, 0, 0, 2'b11, 4'b1010, 4'b0110); step("R4 src1 pattern A");
        drive(0, 0, 0, 2'b11, 4'b0000, 4'b1001); step("R4 src1 pattern B");
        drive(0, 0, 0, 2'b10, 4'b1010, 4'b0110); step("R2 or pattern A");
        drive(0, 0, 0, 2'b10, 4'b0001, 4'b1000); step("R8 lanes independent");
        drive(0, 0, 0, 2'b11, 4'b0000, 4'b1111); step("R4 load ones");
        drive(0, 0, 0, 2'b01, 4'b1111, 4'b1111); step("R3 forced zero");
        drive(0, 0, 0, 2'b11, 4'b0000, 4'b1011); step("R4 reload");
        drive(0, 1, 0, 2'b00, 4'b0100, 4'b0000); step("R5 hold en_a_n high");
        drive(0, 0, 1, 2'b01, 4'b0000, 4'b0000); step("R5 hold en_b_n high");
        drive(0, 1, 1, 2'b10, 4'b1111, 4'b1111); step("R5 hold both high");
        drive(1, 1, 1, 2'b11, 4'b1111, 4'b1111); step("R6 clear with enables high");
        drive(0, 0, 0, 2'b11, 4'b1111, 4'b0110); step("R4 after clear");
        drive(1, 0, 0, 2'b10, 4'b1111, 4'b1111); step("R6 clear overrides transparent");
        for (int n = 0; n < 400; n++) begin
            drive(($urandom % 16) == 0, ($urandom % 3) == 0, ($urandom % 3) == 0,
                  2'($urandom), LANES'($urandom), LANES'($urandom));
            step("R1-4 random mix, R5 R6 R8");
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule